// File: doc/BRIEF.md
# Separate-I/O Burst-of-Four Double-Data-Rate SRAM

This block is a synthesizable behavioural model of a static memory with one input data bus and one output data bus. A single address and two active-low selects are sampled on the rising clock edge. Every accepted operation moves a burst of four words. The words cross the data buses on both clock edges, so one burst takes two clock cycles. The storage array is small, and its word width and address width are parameters.

Write data arrives one cycle after the command and is taken on four consecutive edges, alternating rising and falling. Read data leaves two and a half cycles after the command, again on four consecutive edges. At every other moment the output bus floats. Since the buses are separate, the tail of one burst can overlap the head of the next burst, in either direction. Commands are taken only on every second rising edge counted from reset. The model holds its array as rows of four words. The two low address bits are ignored, so each burst covers one aligned row.

Top module: `qdr_burst4_sram`

## Requirements
- R1: On an accepting edge, `rd_n` low starts a read whatever `wr_n` is. `rd_n` high with `wr_n` low starts a write. Both high is a deselect, which drives no output and changes no memory.
- R2: The first rising edge after reset accepts commands, and after that every second rising edge does. Selects and address on the other rising edges are ignored: they start no read output and change no memory.
- R3: For a write sampled at rising edge n, word k (k = 0..3) of the burst is taken from `din` at edge n+1 (rising), n+1½ (falling), n+2 (rising) and n+2½ (falling), in that order. Back-to-back writes are all stored.
- R4: For a read sampled at rising edge n, word k is driven on `dout` with `dout_en` high. Each word lasts one half-cycle, in the halves that start at n+2½, n+3, n+3½ and n+4.
- R5: In every half-cycle that holds no scheduled read word, `dout_en` is low and `dout` is high impedance. This includes the halves after writes and deselects.
- R6: The burst base is the address with its two least significant bits cleared. Word k of the burst uses location base+k, so addresses 0x09 and 0x08 select the same four locations.
- R7: A read accepted right after a write to the same base returns the newly written words.
- R8: A write accepted right after a read proceeds while the read's last two words are still on `dout`. Both operations complete correctly.
- R9: Reads on consecutive accepting edges produce eight words on `dout` with no gap in `dout_en`.
- R10: A synchronous active-high `rst` cancels all pending operations, including read words not yet driven, and forces `dout_en` low. It leaves the array contents unchanged, and the first rising edge with `rst` low accepts commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples commands, both edges move data |
| rst | input | 1 | Synchronous active-high reset, sampled on both edges |
| addr | input | AW | Word address; two low bits ignored |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| din | input | DW | Write data, sampled on both edges |
| dout | output | DW | Read data, high impedance when idle |
| dout_en | output | 1 | High while `dout` carries a read word |

## Verification
The bench aims at the half-cycle seams where read and write bursts overlap. A write followed at once by a read of the same row would return stale data if the array update came after the fetch. A write issued straight after a read would lose words if the two bursts shared capture or drive state. It drives selects on the ignored odd edges with data that would corrupt a row, so a design that lets those edges through changes memory or sends out phantom words. It also asserts reset while a read is partly on the bus: a design that does not cancel the pending stages would keep driving words after the reset.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BURST_LEN = 4;
    localparam int BURST_LG  = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/qdr_cmd_ctrl.sv
module qdr_cmd_ctrl #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [ROW_W-1:0] row_in,
    output logic             cmd_take,
    output logic             cap_first,
    output logic             cap_mid,
    output logic             commit,
    output logic [ROW_W-1:0] commit_row,
    output logic             fetch,
    output logic [ROW_W-1:0] fetch_row,
    output logic             beat_lo,
    output logic             beat_hi
);
    import qdr_pkg::*;

    typedef struct packed {
        logic             odd_slot;
        op_e              s1_op;
        logic [ROW_W-1:0] s1_row;
        logic             w1_v;
        logic [ROW_W-1:0] w1_row;
        logic             w2_v;
        logic [ROW_W-1:0] w2_row;
        logic             rf_v;
        logic [ROW_W-1:0] rf_row;
        logic             ra;
        logic             rb;
    } ctrl_t;

    ctrl_t st_d, st_q;
    op_e   op_new;

    always_comb begin
        op_new = OP_NONE;
        if (!st_q.odd_slot) begin
            if (!rd_n)      op_new = OP_READ;
            else if (!wr_n) op_new = OP_WRITE;
        end
        st_d          = st_q;
        st_d.odd_slot = ~st_q.odd_slot;
        st_d.s1_op    = op_new;
        st_d.s1_row   = row_in;
        // write path: word 0 next edge, words 1..2 the edge after, commit last
        st_d.w1_v     = (st_q.s1_op == OP_WRITE);
        st_d.w1_row   = st_q.s1_row;
        st_d.w2_v     = st_q.w1_v;
        st_d.w2_row   = st_q.w1_row;
        // read path: one idle stage so a preceding write has landed
        st_d.rf_v     = (st_q.s1_op == OP_READ);
        st_d.rf_row   = st_q.s1_row;
        st_d.ra       = st_q.rf_v;
        st_d.rb       = st_q.ra;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cmd_take   = (st_q.s1_op != OP_NONE);
    assign cap_first  = (st_q.s1_op == OP_WRITE);
    assign cap_mid    = st_q.w1_v;
    assign commit     = st_q.w2_v;
    assign commit_row = st_q.w2_row;
    assign fetch      = st_q.rf_v;
    assign fetch_row  = st_q.rf_row;
    assign beat_lo    = st_q.ra;
    assign beat_hi    = st_q.rb;
endmodule

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          cap_first,
    input  logic                          cap_mid,
    input  logic [DW-1:0]                 din,
    output logic [qdr_pkg::BURST_LEN*DW-1:0] row_data
);
    typedef struct packed {
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
        logic [DW-1:0] w2;
    } cap_t;

    cap_t          cap_d, cap_q;
    logic [DW-1:0] fall_q;

    always_ff @(negedge clk) begin
        fall_q <= din;
    end

    always_comb begin
        cap_d = cap_q;
        if (cap_first) cap_d.w0 = din;
        if (cap_mid) begin
            cap_d.w1 = fall_q;
            cap_d.w2 = din;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    // the last word is still in the falling-edge register at commit time
    assign row_data = {fall_q, cap_q.w2, cap_q.w1, cap_q.w0};
endmodule

// File: rtl/qdr_row_array.sv
module qdr_row_array #(
    parameter int ROW_W = 4,
    parameter int RW    = 64
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] wrow,
    input  logic [RW-1:0]    wdata,
    input  logic             re,
    input  logic [ROW_W-1:0] rrow,
    output logic [RW-1:0]    rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [RW-1:0] mem [ROWS];
    logic [RW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (re) rd_d = mem[rrow];
    end

    always_ff @(posedge clk) begin
        if (we) mem[wrow] <= wdata;
        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/qdr_rd_drive.sv
module qdr_rd_drive #(
    parameter int DW = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             beat_lo,
    input  logic                             beat_hi,
    input  logic [qdr_pkg::BURST_LEN*DW-1:0] row,
    output logic                             rise_en,
    output logic [DW-1:0]                    dout,
    output logic                             dout_en
);
    import qdr_pkg::*;

    typedef struct packed {
        logic          en;
        logic [DW-1:0] dat;
    } half_t;

    logic [DW-1:0] word [BURST_LEN];
    half_t rise_d, rise_q, fall_d, fall_q;

    for (genvar k = 0; k < BURST_LEN; k++) begin : g_word
        assign word[k] = row[k*DW +: DW];
    end

    // falling edges carry words 0 and 2, rising edges words 1 and 3
    always_comb begin
        fall_d.en  = beat_lo | beat_hi;
        fall_d.dat = beat_lo ? word[0] : word[2];
        rise_d.en  = beat_lo | beat_hi;
        rise_d.dat = beat_lo ? word[1] : word[3];
        if (rst) begin
            fall_d = '0;
            rise_d = '0;
        end
    end

    always_ff @(negedge clk) begin
        fall_q <= fall_d;
    end

    always_ff @(posedge clk) begin
        rise_q <= rise_d;
    end

    assign rise_en = rise_q.en;
    assign dout_en = clk ? rise_q.en : fall_q.en;
    assign dout    = dout_en ? (clk ? rise_q.dat : fall_q.dat) : 'z;
endmodule

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    import qdr_pkg::*;

    localparam int ROW_W = AW - BURST_LG;
    localparam int RW    = BURST_LEN * DW;

    logic             cmd_take, cap_first, cap_mid, commit, fetch;
    logic             beat_lo, beat_hi, rise_en;
    logic [ROW_W-1:0] commit_row, fetch_row;
    logic [RW-1:0]    wr_row_data, rd_row_data;

    qdr_cmd_ctrl #(.ROW_W(ROW_W)) u_ctrl (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .row_in(addr[AW-1:BURST_LG]),
        .cmd_take(cmd_take), .cap_first(cap_first), .cap_mid(cap_mid),
        .commit(commit), .commit_row(commit_row),
        .fetch(fetch), .fetch_row(fetch_row),
        .beat_lo(beat_lo), .beat_hi(beat_hi)
    );

    qdr_wr_capture #(.DW(DW)) u_cap (
        .clk(clk), .cap_first(cap_first), .cap_mid(cap_mid),
        .din(din), .row_data(wr_row_data)
    );

    qdr_row_array #(.ROW_W(ROW_W), .RW(RW)) u_mem (
        .clk(clk), .we(commit), .wrow(commit_row), .wdata(wr_row_data),
        .re(fetch), .rrow(fetch_row), .rdata(rd_row_data)
    );

    qdr_rd_drive #(.DW(DW)) u_drv (
        .clk(clk), .rst(rst), .beat_lo(beat_lo), .beat_hi(beat_hi),
        .row(rd_row_data), .rise_en(rise_en),
        .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: rtl/qdr_burst4_sram_chk.sv
module qdr_burst4_sram_chk (
    input logic clk,
    input logic rst,
    input logic cmd_take,
    input logic cap_first,
    input logic cap_mid,
    input logic commit,
    input logic beat_lo,
    input logic beat_hi,
    input logic rise_en
);
    assert_alt_accept_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_take |=> !cmd_take);

    assert_wr_mid_R3: assert property (@(posedge clk) disable iff (rst)
        cap_first |=> cap_mid);

    assert_wr_commit_R3: assert property (@(posedge clk) disable iff (rst)
        cap_mid |=> commit);

    assert_rd_second_R4: assert property (@(posedge clk) disable iff (rst)
        beat_lo |=> beat_hi);

    assert_rd_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_lo || beat_hi) |=> rise_en);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!beat_lo && !beat_hi) |=> !rise_en);

    assert_no_double_R9: assert property (@(posedge clk) disable iff (rst)
        !(beat_lo && beat_hi));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!cmd_take && !beat_lo && !beat_hi && !commit && !rise_en));
endmodule

bind qdr_burst4_sram qdr_burst4_sram_chk u_chk (
    .clk(clk), .rst(rst), .cmd_take(cmd_take), .cap_first(cap_first),
    .cap_mid(cap_mid), .commit(commit), .beat_lo(beat_lo),
    .beat_hi(beat_hi), .rise_en(rise_en)
);

// File: tb/sim_qdr_burst4_sram.sv
module sim_qdr_burst4_sram;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int E0 = 10;          // edge index of accepting cycle 0
    localparam int LAST_EDGE = E0 + 2 * 52;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    qdr_burst4_sram #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #2.5 clk = ~clk;

    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    bit            exp_en  [int];
    logic [DW-1:0] exp_dat [int];
    string         exp_tag [int];
    bit            c_rdn   [int];
    bit            c_wrn   [int];
    logic [AW-1:0] c_addr  [int];
    logic [DW-1:0] din_at  [int];
    bit            rst_at  [int];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic int cyc_edge(int c);
        return E0 + 2 * c;
    endfunction

    task automatic put_cmd(int c, bit rdn, bit wrn, logic [AW-1:0] a);
        c_rdn[c] = rdn; c_wrn[c] = wrn; c_addr[c] = a;
    endtask

    task automatic do_write(int c, logic [AW-1:0] a, logic [DW-1:0] base);
        put_cmd(c, 1'b1, 1'b0, a);
        for (int k = 0; k < 4; k++) begin
            din_at[cyc_edge(c) + 2 + k] = base + DW'(k);
            ref_mem[{a[AW-1:2], 2'(k)}] = base + DW'(k);
        end
    endtask

    task automatic do_read(int c, logic [AW-1:0] a, bit wrn, string tag);
        put_cmd(c, 1'b0, wrn, a);
        for (int k = 0; k < 4; k++) begin
            int e = cyc_edge(c) + 5 + k;
            exp_en[e]  = 1'b1;
            exp_dat[e] = ref_mem[{a[AW-1:2], 2'(k)}];
            exp_tag[e] = tag;
        end
    endtask

    task automatic check_half(int e);
        bit    want;
        string tag;
        want = exp_en.exists(e);
        if (exp_tag.exists(e)) tag = exp_tag[e];
        else tag = (e < E0) ? "R10" : "R5";
        n_chk++;
        if (dout_en !== want) begin
            n_bad++;
            $display("FAIL %s half %0d: dout_en=%b expected %b", tag, e, dout_en, want);
        end else if (want && dout !== exp_dat[e]) begin
            n_bad++;
            $display("FAIL %s half %0d: dout=%h expected %h", tag, e, dout, exp_dat[e]);
        end
    endtask

    task automatic drive_for(int e);
        rst <= (e < E0) || rst_at.exists(e);
        if (e % 2 == 0) begin
            int c = (e - E0) / 2;
            rd_n <= (e >= E0 && c_rdn.exists(c)) ? c_rdn[c] : 1'b1;
            wr_n <= (e >= E0 && c_wrn.exists(c)) ? c_wrn[c] : 1'b1;
            addr <= (e >= E0 && c_addr.exists(c)) ? c_addr[c] : AW'(e);
        end
        din <= din_at.exists(e) ? din_at[e] : (DW'(16'hA5A5) ^ DW'(e));
    endtask

    initial begin
        // R6: low address bits ignored on write; R7: read right after write
        do_write(0, 6'h09, 16'h1100);
        do_read(2, 6'h08, 1'b1, "R7");
        // R8: write while the read still drives
        do_write(4, 6'h10, 16'h2200);
        do_read(6, 6'h12, 1'b1, "R6");
        // R1: read wins over write select
        do_read(8, 6'h08, 1'b0, "R1");
        // R1: deselect is silent
        put_cmd(10, 1'b1, 1'b1, 6'h08);
        for (int e = cyc_edge(10) + 5; e <= cyc_edge(10) + 8; e++) exp_tag[e] = "R1";
        // R2: commands on odd cycles are ignored
        put_cmd(11, 1'b1, 1'b0, 6'h08);
        put_cmd(13, 1'b0, 1'b1, 6'h10);
        for (int e = cyc_edge(13) + 5; e <= cyc_edge(13) + 6; e++) exp_tag[e] = "R2";
        do_read(14, 6'h08, 1'b1, "R2");
        // R9: back-to-back reads
        do_read(16, 6'h10, 1'b1, "R9");
        do_read(18, 6'h08, 1'b1, "R9");
        // R3: back-to-back writes, then reads at edge rows
        do_write(20, 6'h3C, 16'h3300);
        do_write(22, 6'h00, 16'h4400);
        do_read(24, 6'h3F, 1'b1, "R3");
        do_read(26, 6'h00, 1'b1, "R4");
        // R10: reset while a read is on the bus
        do_write(30, 6'h20, 16'h5500);
        do_read(38, 6'h20, 1'b1, "R10");
        rst_at[cyc_edge(41)] = 1'b1;
        rst_at[cyc_edge(41) + 1] = 1'b1;
        for (int e = cyc_edge(41); e <= cyc_edge(41) + 2; e++) begin
            exp_en.delete(e);
            exp_tag[e] = "R10";
        end
        do_read(42, 6'h20, 1'b1, "R10");
        do_write(44, 6'h24, 16'h6600);
        do_read(46, 6'h24, 1'b1, "R8");

        drive_for(0);
        for (int e = 0; e <= LAST_EDGE; e++) begin
            @(clk);
            #1.25;
            check_half(e);
            drive_for(e + 1);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule